// File: doc/BRIEF.md
# Biopotential ADC Bring-Up Sequencer

This block is a hardware state machine that configures a two-channel biopotential ADC over SPI without any processor involvement. Leaving reset, it sends the command that ends continuous data read. It then soft-resets the converter and sends the stop-continuous command a second time. After each of these commands it waits the time the converter needs. Next it reads the identification register and compares it with the expected identity.

It then walks a table of address/value pairs supplied on its inputs. Each entry is written and then read back to confirm it. After the last confirmed entry it sends the start-conversion command.

The block talks to a byte-wide SPI master through a launch strobe, a transmit byte, a receive byte and a busy flag. It owns the chip-select line. Its result is reported as `done` with a two-bit status: success, bad identity, or readback mismatch. A `restart` pulse, accepted once the block has finished, runs the whole sequence again.

Top module: `adc_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `cs_n` is 1, `spi_go` is 0, `done` is 0 and `status` is 0.
- R2: The commands follow a fixed order:
  - stop-continuous 0x11, reset 0x06, stop-continuous 0x11;
  - an identity read 0x20, 0x00, 0x00;
  - for each table entry k (below `tbl_len`), a write 0x40|addr, 0x00, value followed by a read 0x20|addr, 0x00, 0x00;
  - finally start 0x08.
  The second byte of a register command carries count−1 (0) in its low 5 bits. The byte received during the third byte of a read is the register content.
- R3: After the reset command, `cs_n` stays high for at least ceil(9·SYS_CLK_HZ/MOD_CLK_HZ) clock cycles before the next command.
- R4: After each stop-continuous command, `cs_n` stays high for at least ceil(4·SYS_CLK_HZ/DEV_CLK_HZ) clock cycles before the next command.
- R5: `cs_n` stays low across every byte of one command and is high for at least CS_GAP cycles between commands. `spi_go` is asserted only while `cs_n` is low and `spi_busy` is low.
- R6: If the identity byte differs from DEV_ID (0x73), the sequence stops after the identity read with `done`=1 and `status`=1. No further command is sent.
- R7: If a readback differs from the value written, the sequence stops after that read with `done`=1 and `status`=2. No start command is sent.
- R8: After the start command, `done`=1, `busy`=0 and `status`=0.
- R9: With `tbl_len`=0 the identity read is followed directly by the start command. `tbl_len` ranges from 0 to MAX_REGS.
- R10: `restart` while `done` is 1 reruns the sequence from the first stop-continuous command. `restart` while `busy` is 1 has no effect.
- R11: While `done` is 1 and no restart arrives, `done` and `status` hold and no command is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Rerun the sequence (accepted when done) |
| tbl_addr | input | 5·MAX_REGS | Register address of entry k at bits [5k+4:5k] |
| tbl_data | input | 8·MAX_REGS | Value of entry k at bits [8k+7:8k] |
| tbl_len | input | $clog2(MAX_REGS+1) | Number of table entries used |
| spi_go | output | 1 | Launch one byte on the SPI master |
| spi_txd | output | 8 | Byte to transmit |
| spi_rxd | input | 8 | Byte received, valid when spi_busy falls |
| spi_busy | input | 1 | SPI master is shifting a byte |
| cs_n | output | 1 | Active-low chip select to the converter |
| done | output | 1 | Sequence finished |
| busy | output | 1 | Sequence in progress |
| status | output | 2 | 0 success, 1 bad identity, 2 readback mismatch |

## Verification
The assertions check the following on every cycle:
- the SPI handshake rule: no launch while busy or deselected;
- the minimum chip-select gap between commands;
- that a byte completes only while selected;
- that status, done and chip select stay quiet and stable after completion;
- that a restart from the done state is taken.

Only the bench scenarios can show the rest:
- the full command order, including the byte contents;
- the long reset and stop-continuous waits measured between frames;
- the abort paths on a wrong identity and on a corrupted readback;
- the empty-table path;
- that a restart during a run leaves the command count unchanged.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam logic [7:0] OP_WAKEUP    = 8'h02;
  localparam logic [7:0] OP_STANDBY   = 8'h04;
  localparam logic [7:0] OP_RESET     = 8'h06;
  localparam logic [7:0] OP_START     = 8'h08;
  localparam logic [7:0] OP_STOP      = 8'h0A;
  localparam logic [7:0] OP_RDATAC    = 8'h10;
  localparam logic [7:0] OP_SDATAC    = 8'h11;
  localparam logic [7:0] OP_RDATA     = 8'h12;
  localparam logic [7:0] OP_OFFSETCAL = 8'h1A;
  localparam logic [7:0] OP_RREG      = 8'h20;
  localparam logic [7:0] OP_WREG      = 8'h40;

  typedef enum logic [1:0] {
    RES_OK       = 2'd0,
    RES_BAD_ID   = 2'd1,
    RES_READBACK = 2'd2
  } result_e;

  typedef enum logic [3:0] {
    PH_SDATAC_A, PH_RESET, PH_SDATAC_B, PH_ID,
    PH_WRITE, PH_VERIFY, PH_START, PH_HOLD, PH_DONE
  } phase_e;

  // system clock cycles covering 'ticks' periods of a slower clock, rounded up
  function automatic int unsigned cycles_for(input int unsigned ticks,
                                             input longint unsigned sys_hz,
                                             input longint unsigned slow_hz);
    logic [63:0] num;
    num = 64'(ticks) * 64'(sys_hz) + 64'(slow_hz) - 64'd1;
    return 32'(num / 64'(slow_hz));
  endfunction

  // register command opcode: base opcode with the 5-bit address in the low bits
  function automatic logic [7:0] reg_cmd(input logic [7:0] base, input logic [4:0] addr);
    return base | {3'b000, addr};
  endfunction
endpackage

// File: rtl/adc_cmd_xfer.sv
// Sends one framed command of 1..3 bytes through the byte-wide SPI master,
// holding chip select for the whole frame, then enforces the deselect gap.
module adc_cmd_xfer #(
  parameter int unsigned CS_GAP = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [1:0]  nbytes,
  input  logic [23:0] bytes_in,
  output logic        done,
  output logic [7:0]  rx_last,
  output logic        byte_done,
  output logic        cs_n,
  output logic        spi_go,
  output logic [7:0]  spi_txd,
  input  logic [7:0]  spi_rxd,
  input  logic        spi_busy
);
  localparam int unsigned GAP_W = $clog2(CS_GAP + 1);

  typedef enum logic [2:0] {X_IDLE, X_ISSUE, X_WAITHI, X_WAITLO, X_GAP} xst_e;

  xst_e             st;
  logic [23:0]      sh;
  logic [1:0]       left;
  logic [GAP_W-1:0] gcnt;

  assign spi_go    = (st == X_ISSUE) && !spi_busy;
  assign spi_txd   = sh[7:0];
  assign byte_done = (st == X_WAITLO) && !spi_busy;
  assign cs_n      = !((st == X_ISSUE) || (st == X_WAITHI) || (st == X_WAITLO));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= X_IDLE;
      sh      <= '0;
      left    <= '0;
      gcnt    <= '0;
      rx_last <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        X_IDLE: if (req) begin
          sh   <= bytes_in;
          left <= nbytes - 2'd1;
          st   <= X_ISSUE;
        end
        X_ISSUE:  if (!spi_busy) st <= X_WAITHI;
        X_WAITHI: if (spi_busy) st <= X_WAITLO;
        X_WAITLO: if (!spi_busy) begin
          rx_last <= spi_rxd;
          if (left == 2'd0) begin
            st   <= X_GAP;
            gcnt <= '0;
          end else begin
            left <= left - 2'd1;
            sh   <= {8'h00, sh[23:8]};
            st   <= X_ISSUE;
          end
        end
        X_GAP: begin
          if (gcnt == GAP_W'(CS_GAP - 1)) begin
            st   <= X_IDLE;
            done <= 1'b1;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        default: st <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_wait_timer.sv
// Down counter: load a cycle count, 'expired' is high once it reaches zero.
module adc_wait_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] count,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= count;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_bringup_seq.sv
module adc_bringup_seq
  import adc_seq_pkg::*;
#(
  parameter longint unsigned SYS_CLK_HZ = 200_000_000,
  parameter longint unsigned DEV_CLK_HZ = 512_000,
  parameter longint unsigned MOD_CLK_HZ = 128_000,
  parameter int unsigned     CS_GAP     = 4,
  parameter int unsigned     MAX_REGS   = 10,
  parameter logic [7:0]      DEV_ID     = 8'h73,
  localparam int unsigned    IDX_W      = $clog2(MAX_REGS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  restart,
  input  logic [MAX_REGS*5-1:0] tbl_addr,
  input  logic [MAX_REGS*8-1:0] tbl_data,
  input  logic [IDX_W-1:0]      tbl_len,
  output logic                  spi_go,
  output logic [7:0]            spi_txd,
  input  logic [7:0]            spi_rxd,
  input  logic                  spi_busy,
  output logic                  cs_n,
  output logic                  done,
  output logic                  busy,
  output logic [1:0]            status
);
  localparam int unsigned RESET_WAIT  = cycles_for(9, SYS_CLK_HZ, MOD_CLK_HZ);
  localparam int unsigned SDATAC_WAIT = cycles_for(4, SYS_CLK_HZ, DEV_CLK_HZ);
  localparam int unsigned MAX_WAIT    = (RESET_WAIT > SDATAC_WAIT) ? RESET_WAIT : SDATAC_WAIT;
  localparam int unsigned WAIT_W      = $clog2(MAX_WAIT + 1);

  // table unpacking
  logic [4:0] addr_arr [MAX_REGS];
  logic [7:0] val_arr  [MAX_REGS];
  for (genvar g = 0; g < MAX_REGS; g++) begin : g_tbl
    assign addr_arr[g] = tbl_addr[g*5 +: 5];
    assign val_arr[g]  = tbl_data[g*8 +: 8];
  end

  phase_e           ph, ph_after;
  result_e          res;
  logic             launched;
  logic [IDX_W-1:0] idx;

  // named internal events
  logic        cmd_req, cmd_done, byte_done, cmd_phase;
  logic [1:0]  cmd_n;
  logic [23:0] cmd_bytes;
  logic [7:0]  rx_last;
  logic        tmr_load, tmr_expired;
  logic [WAIT_W-1:0] tmr_count;
  logic [4:0]  cur_addr;
  logic [7:0]  cur_val;

  assign cur_addr  = addr_arr[idx];
  assign cur_val   = val_arr[idx];
  assign cmd_phase = (ph == PH_SDATAC_A) || (ph == PH_RESET) || (ph == PH_SDATAC_B) ||
                     (ph == PH_ID) || (ph == PH_WRITE) || (ph == PH_VERIFY) ||
                     (ph == PH_START);
  assign cmd_req   = cmd_phase && !launched;

  always_comb begin
    cmd_n     = 2'd1;
    cmd_bytes = 24'h0;
    case (ph)
      PH_SDATAC_A, PH_SDATAC_B: cmd_bytes = {16'h0, OP_SDATAC};
      PH_RESET:                 cmd_bytes = {16'h0, OP_RESET};
      PH_START:                 cmd_bytes = {16'h0, OP_START};
      PH_ID: begin
        cmd_n     = 2'd3;
        cmd_bytes = {8'h00, 8'h00, reg_cmd(OP_RREG, 5'd0)};
      end
      PH_WRITE: begin
        cmd_n     = 2'd3;
        cmd_bytes = {cur_val, 8'h00, reg_cmd(OP_WREG, cur_addr)};
      end
      PH_VERIFY: begin
        cmd_n     = 2'd3;
        cmd_bytes = {8'h00, 8'h00, reg_cmd(OP_RREG, cur_addr)};
      end
      default: ;
    endcase
  end

  assign tmr_load  = cmd_done && ((ph == PH_SDATAC_A) || (ph == PH_RESET) || (ph == PH_SDATAC_B));
  assign tmr_count = (ph == PH_RESET) ? WAIT_W'(RESET_WAIT) : WAIT_W'(SDATAC_WAIT);

  adc_cmd_xfer #(.CS_GAP(CS_GAP)) u_xfer (
    .clk(clk), .rst_n(rst_n), .req(cmd_req), .nbytes(cmd_n), .bytes_in(cmd_bytes),
    .done(cmd_done), .rx_last(rx_last), .byte_done(byte_done), .cs_n(cs_n),
    .spi_go(spi_go), .spi_txd(spi_txd), .spi_rxd(spi_rxd), .spi_busy(spi_busy)
  );

  adc_wait_timer #(.W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .count(tmr_count), .expired(tmr_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_SDATAC_A;
      ph_after <= PH_RESET;
      res      <= RES_OK;
      launched <= 1'b0;
      idx      <= '0;
    end else begin
      if (cmd_req) launched <= 1'b1;
      if (cmd_done) begin
        launched <= 1'b0;
        case (ph)
          PH_SDATAC_A: begin ph <= PH_HOLD; ph_after <= PH_RESET;    end
          PH_RESET:    begin ph <= PH_HOLD; ph_after <= PH_SDATAC_B; end
          PH_SDATAC_B: begin ph <= PH_HOLD; ph_after <= PH_ID;       end
          PH_ID: begin
            idx <= '0;
            if (rx_last != DEV_ID) begin
              res <= RES_BAD_ID;
              ph  <= PH_DONE;
            end else begin
              ph <= (tbl_len == '0) ? PH_START : PH_WRITE;
            end
          end
          PH_WRITE: ph <= PH_VERIFY;
          PH_VERIFY: begin
            if (rx_last != cur_val) begin
              res <= RES_READBACK;
              ph  <= PH_DONE;
            end else if ((idx + IDX_W'(1)) == tbl_len) begin
              ph <= PH_START;
            end else begin
              idx <= idx + IDX_W'(1);
              ph  <= PH_WRITE;
            end
          end
          PH_START: ph <= PH_DONE;
          default: ;
        endcase
      end else if (ph == PH_HOLD) begin
        if (tmr_expired) ph <= ph_after;
      end else if (ph == PH_DONE) begin
        if (restart) begin
          ph  <= PH_SDATAC_A;
          res <= RES_OK;
          idx <= '0;
        end
      end
    end
  end

  assign done   = (ph == PH_DONE);
  assign busy   = !done;
  assign status = res;
endmodule

// File: rtl/adc_bringup_chk.sv
module adc_bringup_chk #(
  parameter int unsigned CS_GAP = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       spi_go,
  input logic       spi_busy,
  input logic       byte_done,
  input logic       restart,
  input logic       done,
  input logic       busy,
  input logic [1:0] status
);
  int unsigned gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 gap_cnt <= CS_GAP;
    else if (!cs_n)             gap_cnt <= 0;
    else if (gap_cnt < CS_GAP)  gap_cnt <= gap_cnt + 1;
  end

  // R5: a byte is launched only while selected and the master is idle
  a_r5_go_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> (!cs_n && !spi_busy));

  // R5: deselect lasts at least CS_GAP cycles before a new command
  a_r5_cs_gap: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (gap_cnt >= CS_GAP));

  // R5: a byte finishes only inside a selected frame
  a_r5_byte_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !cs_n);

  // R6 / R7: an error code appears only with done
  a_r6_status_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'd0) |-> done);

  // R11: finished state holds without restart
  a_r11_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !restart) |=> (done && $stable(status)));

  // R11: no bus activity once finished
  a_r11_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && !spi_go));

  // R10: restart from done starts a new run
  a_r10_restart_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (done && restart) |=> busy);
endmodule

bind adc_bringup_seq adc_bringup_chk #(.CS_GAP(CS_GAP)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .spi_go(spi_go), .spi_busy(spi_busy),
  .byte_done(byte_done), .restart(restart), .done(done), .busy(busy), .status(status)
);

// File: tb/adc_bringup_seq_test.sv
`timescale 1ns/1ps
module adc_bringup_seq_test;
  localparam int MAXR = 10;
  localparam int CSG  = 4;
  localparam int RESET_EXP  = int'($ceil(9.0 * 200.0e6 / 128.0e3));
  localparam int SDATAC_EXP = int'($ceil(4.0 * 200.0e6 / 512.0e3));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic restart = 1'b0;
  logic [MAXR*5-1:0] tbl_addr;
  logic [MAXR*8-1:0] tbl_data;
  logic [3:0] tbl_len = 4'd10;
  logic spi_go, cs_n, done, busy;
  logic [7:0] spi_txd;
  logic [7:0] spi_rxd = 8'h00;
  logic spi_busy = 1'b0;
  logic [1:0] status;

  always #2.5 clk = ~clk;

  adc_bringup_seq uut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .tbl_len(tbl_len), .spi_go(spi_go), .spi_txd(spi_txd), .spi_rxd(spi_rxd),
    .spi_busy(spi_busy), .cs_n(cs_n), .done(done), .busy(busy), .status(status)
  );

  // converter model and frame log
  logic [7:0] vals [MAXR];
  logic [7:0] dev_regs [32];
  logic [7:0] dev_id_cfg = 8'h73;
  logic [4:0] bad_addr = 5'd31;
  logic clr_log = 1'b0;
  logic [7:0] op_r, m_resp;
  logic [7:0] fb [3];
  int m_cnt, pos, cyc, nf;
  logic cs_q;
  logic [7:0] f_op [64], f_b1 [64], f_b2 [64];
  int f_len [64], f_start [64], f_end [64];

  initial begin
    cyc = 0; nf = 0; pos = 0; m_cnt = 0; cs_q = 1'b1;
  end

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    cs_q <= cs_n;
    if (clr_log) begin
      nf <= 0;
      dev_regs[0] <= dev_id_cfg;
      for (int i = 1; i < 32; i++) dev_regs[i] <= 8'h00;
    end
    if (!rst_n) begin
      spi_busy <= 1'b0; m_cnt <= 0; pos <= 0; spi_rxd <= 8'h00;
    end else begin
      if (spi_go && !spi_busy) begin
        spi_busy <= 1'b1;
        m_cnt <= 2;
        if (pos < 3) fb[pos] <= spi_txd;
        if (pos == 0) op_r <= spi_txd;
        if (pos == 2 && op_r[7:5] == 3'b001)
          m_resp <= dev_regs[op_r[4:0]] ^ ((op_r[4:0] == bad_addr) ? 8'h01 : 8'h00);
        else
          m_resp <= 8'h00;
        if (pos == 2 && op_r[7:5] == 3'b010) dev_regs[op_r[4:0]] <= spi_txd;
        pos <= pos + 1;
      end else if (spi_busy) begin
        if (m_cnt == 0) begin
          spi_busy <= 1'b0;
          spi_rxd <= m_resp;
        end else m_cnt <= m_cnt - 1;
      end
      if (!cs_n && cs_q && nf < 64 && !clr_log) f_start[nf] <= cyc;
      if (cs_n && !cs_q && nf < 64 && !clr_log) begin
        f_end[nf] <= cyc; f_op[nf] <= fb[0]; f_b1[nf] <= fb[1]; f_b2[nf] <= fb[2];
        f_len[nf] <= pos; nf <= nf + 1; pos <= 0;
      end
    end
  end

  int n_checks = 0, n_fail = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic [7:0] e_op [64], e_b1 [64], e_b2 [64];
  int e_len [64];
  int ne;

  task automatic push(input logic [7:0] op, input logic [7:0] b1, input logic [7:0] b2, input int l);
    e_op[ne] = op; e_b1[ne] = b1; e_b2[ne] = b2; e_len[ne] = l; ne++;
  endtask

  // expected command list built from R2, R6, R7, R9
  task automatic build_exp(input int len, input bit id_bad, input int bad_entry);
    ne = 0;
    push(8'h11, 0, 0, 1); push(8'h06, 0, 0, 1); push(8'h11, 0, 0, 1);
    push(8'h20, 8'h00, 8'h00, 3);
    if (id_bad) return;
    for (int i = 0; i < len; i++) begin
      push(8'h40 | 8'(i + 1), 8'h00, vals[i], 3);
      push(8'h20 | 8'(i + 1), 8'h00, 8'h00, 3);
      if (i == bad_entry) return;
    end
    push(8'h08, 0, 0, 1);
  endtask

  task automatic verify_frames(input string tag);
    check(nf == ne, {tag, " command count"}, nf, ne);
    for (int i = 0; i < ne && i < nf; i++) begin
      check(f_op[i] == e_op[i], {tag, " opcode"}, f_op[i], e_op[i]);
      check(f_len[i] == e_len[i], {tag, " frame length"}, f_len[i], e_len[i]);
      if (e_len[i] == 3) begin
        check(f_b1[i] == e_b1[i], {tag, " count byte"}, f_b1[i], e_b1[i]);
        check(f_b2[i] == e_b2[i], {tag, " data byte"}, f_b2[i], e_b2[i]);
      end
      if (i + 1 < nf)
        check(f_start[i+1] - f_end[i] >= CSG, "R5 chip select gap", f_start[i+1] - f_end[i], CSG);
    end
  endtask

  task automatic check_waits();
    if (nf >= 4) begin
      check(f_start[1] - f_end[0] >= SDATAC_EXP, "R4 wait after first stop", f_start[1] - f_end[0], SDATAC_EXP);
      check(f_start[2] - f_end[1] >= RESET_EXP,  "R3 wait after reset",      f_start[2] - f_end[1], RESET_EXP);
      check(f_start[3] - f_end[2] >= SDATAC_EXP, "R4 wait after second stop", f_start[3] - f_end[2], SDATAC_EXP);
    end
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 40000) begin @(negedge clk); t++; end
    check(done == 1'b1, "run finished", done, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic launch(input logic [7:0] id, input int bad, input int len);
    @(negedge clk);
    dev_id_cfg = id; bad_addr = 5'(bad); tbl_len = 4'(len); clr_log = 1'b1;
    @(negedge clk);
    clr_log = 1'b0; restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  task automatic t_reset_and_full_run();
    clr_log = 1'b1;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    check(spi_go == 1'b0, "R1 spi_go in reset", spi_go, 0);
    check(done == 1'b0, "R1 done in reset", done, 0);
    check(status == 2'd0, "R1 status in reset", status, 0);
    clr_log = 1'b0;
    rst_n = 1'b1;
    wait_done();
    build_exp(10, 1'b0, -1);
    verify_frames("R2 full table");
    check_waits();
    check(status == 2'd0, "R8 status success", status, 0);
    check(busy == 1'b0, "R8 busy cleared", busy, 0);
  endtask

  task automatic t_bad_id();
    launch(8'h72, 31, 10);
    wait_done();
    build_exp(10, 1'b1, -1);
    verify_frames("R6 bad identity");
    check(status == 2'd1, "R6 status", status, 1);
  endtask

  task automatic t_mismatch();
    launch(8'h73, 5, 10);
    wait_done();
    build_exp(10, 1'b0, 4);
    verify_frames("R7 readback mismatch");
    check(status == 2'd2, "R7 status", status, 2);
  endtask

  task automatic t_empty();
    launch(8'h73, 31, 0);
    wait_done();
    build_exp(0, 1'b0, -1);
    verify_frames("R9 empty table");
    check(status == 2'd0, "R9 status", status, 0);
  endtask

  task automatic t_restart_busy();
    launch(8'h73, 31, 3);
    repeat (3000) @(negedge clk);
    check(busy == 1'b1, "R10 busy mid-run", busy, 1);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    wait_done();
    build_exp(3, 1'b0, -1);
    verify_frames("R10 restart ignored while busy");
    check(f_op[0] == 8'h11, "R10 rerun begins with stop-continuous", f_op[0], 8'h11);
  endtask

  task automatic t_hold();
    int n0;
    n0 = nf;
    repeat (100) @(negedge clk);
    check(done == 1'b1, "R11 done holds", done, 1);
    check(status == 2'd0, "R11 status holds", status, 0);
    check(nf == n0, "R11 no commands after done", nf, n0);
  endtask

  initial begin
    for (int i = 0; i < MAXR; i++) begin
      vals[i] = 8'h13 * 8'(i + 1) + 8'h2C;
      tbl_addr[i*5 +: 5] = 5'(i + 1);
      tbl_data[i*8 +: 8] = vals[i];
    end
    t_reset_and_full_run();
    t_hold();
    t_bad_id();
    t_mismatch();
    t_empty();
    t_restart_busy();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule